// File: doc/BRIEF.md
# Indirect Configuration RAM Access Port

This block lets a host reach several per-slot and per-channel configuration memories through only a few bus registers. The host works in two phases. In the first phase it leaves a word in the data register. In the second phase it writes the select register. The select word names a memory bank, an entry within that bank and a direction. Writing the select register is what starts the transfer. While the transfer runs, the block raises a busy flag.

A write transfer copies the held data word into the addressed entry. A read transfer copies the entry into the data register, and the host fetches it from there once busy has dropped. There are two per-slot banks, one for receive and one for transmit. A third bank holds per-channel records, and each record is split into sub-words.

Software commonly uses read-modify-write. A typical case is setting the slot enable flag in bit 15 of a slot entry. To do that it reads the entry, ORs bit 15 into the data register and writes the entry back. Every entry resets to zero, so every slot and every channel starts disabled.

Top module: `cfgwin_port`

## Requirements
- R1: After reset the data register, the select register and busy read 0, and every entry of every bank reads back as 0.
- R2: The host register map is addressed by host_addr. Address 0 is the data register and is read/write. Address 1 is the select register and reads back the last accepted select word. Address 2 is status, with busy in bit 0. Address 3 reads 0. Reads have no side effect.
- R3: An accepted select write raises busy on the next cycle. Busy then stays high for exactly XFER_CYCLES cycles (default 2) and drops on its own.
- R4: Select bit 14 sets the direction. When it is clear, the data register is written into the addressed entry. When it is set, the entry is loaded into the data register, and the loaded value is present by the cycle in which busy reads 0.
- R5: Select bits 9-8 choose the bank: 01 is the receive slot RAM, 10 is the transmit slot RAM and 11 is the channel RAM. For the slot banks, bits 6-0 give the slot index and bit 7 is ignored.
- R6: In the channel bank, bits 7-0 give the channel number and bits 13-11 give the sub-word. Each (channel, sub-word) pair is a separate 16-bit entry.
- R7: Bank code 00 changes no RAM. A read with bank code 00 leaves the data register unchanged.
- R8: While busy is high, host writes to the data register and to the select register are ignored.
- R9: A channel number of NUM_CHANNELS or above writes nothing, and no other channel is touched. A read of such a channel loads 0.
- R10: A read-modify-write that sets bit 15 of a slot entry leaves bits 14-0 of that entry unchanged.
- R11: The banks are independent. A write to one bank's entry never changes the entry with the same index in another bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write access, 0 = read |
| host_addr | input | 2 | Register address (0 data, 1 select, 2 status) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data, combinational from host_addr |
| busy | output | 1 | Transfer in progress |

## Verification
Several corner cases are covered, and each one catches a specific kind of broken design:

- **Writes while busy.** The bench issues a data write and a fresh select write in the middle of a transfer. A design that does not guard against these would commit the stray data or would start a second transfer with the wrong select.
- **Slot bit 7.** Slot accesses are made with bit 7 set. A design that used all eight index bits would then miss the entry.
- **Out-of-range channel.** A channel number of NUM_CHANNELS or above is written. A design that truncates that number would alias the write onto a lower channel.
- **Bank code 00.** Reads and writes are made with bank code 00. A design that defaults this code to some real bank would corrupt that bank or would overwrite the held data.
- **Read-modify-write of bit 15.** The bench runs the enable read-modify-write. This exposes any read path that does not land in the data register before busy falls.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    BANK_NONE = 2'b00,
    BANK_RX   = 2'b01,
    BANK_TX   = 2'b10,
    BANK_CHAN = 2'b11
  } bank_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  function automatic bank_e sel_bank(input logic [WORD_W-1:0] s);
    return bank_e'(s[9:8]);
  endfunction

  function automatic logic sel_is_read(input logic [WORD_W-1:0] s);
    return s[14];
  endfunction

  function automatic logic [6:0] sel_slot(input logic [WORD_W-1:0] s);
    return s[6:0];
  endfunction

  function automatic logic [7:0] sel_chan(input logic [WORD_W-1:0] s);
    return s[7:0];
  endfunction

  function automatic logic [2:0] sel_sub(input logic [WORD_W-1:0] s);
    return s[13:11];
  endfunction

  function automatic logic [WORD_W-1:0] stat_word(input logic bsy);
    return {{(WORD_W-1){1'b0}}, bsy};
  endfunction
endpackage

// File: rtl/cfgwin_bank_ram.sv
module cfgwin_bank_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cfgwin_xfer_ctl.sv
module cfgwin_xfer_ctl #(
  parameter int XFER_CYCLES = 2,
  localparam int CW = $clog2(XFER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic op_done
);
  logic [CW-1:0] cnt_q;

  assign op_done = busy && (cnt_q == CW'(XFER_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy && start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (op_done) busy <= 1'b0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a start while idle raises busy on the next cycle
  assert_start_raises_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3: busy only ends through the transfer step
  assert_busy_ends_on_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(op_done));

  generate
    if (XFER_CYCLES > 1) begin : g_multi
      assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    end
  endgenerate
endmodule

// File: rtl/cfgwin_host_regs.sv
module cfgwin_host_regs
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [1:0]        host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              op_load,
  input  logic [WORD_W-1:0] load_val,
  output logic              start,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] sel_q
);
  logic wr_data, wr_sel;

  assign wr_data = host_valid && host_write && (host_addr == REG_DATA);
  assign wr_sel  = host_valid && host_write && (host_addr == REG_SEL);
  assign start   = wr_sel && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      sel_q  <= '0;
    end else begin
      if (op_load)               data_q <= load_val;
      else if (wr_data && !busy) data_q <= host_wdata;
      if (start)                 sel_q  <= host_wdata;
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_DATA: host_rdata = data_q;
      REG_SEL:  host_rdata = sel_q;
      REG_STAT: host_rdata = stat_word(busy);
      default:  host_rdata = '0;
    endcase
  end

  // R8: data writes during a transfer do not land
  assert_busy_data_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_load && wr_data) |=> $stable(data_q));

  // R8: a select write during a transfer does not replace the select word
  assert_busy_sel_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_sel) |=> $stable(sel_q));
endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
  import cfgwin_pkg::*;
#(
  parameter int NUM_SLOTS    = 128,
  parameter int NUM_CHANNELS = 32,
  parameter int NUM_SUBWORDS = 8,
  parameter int XFER_CYCLES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        busy
);
  localparam int SLOT_AW   = $clog2(NUM_SLOTS);
  localparam int CH_AW     = $clog2(NUM_CHANNELS);
  localparam int SUB_AW    = $clog2(NUM_SUBWORDS);
  localparam int CHAN_DEPTH = NUM_CHANNELS * NUM_SUBWORDS;
  localparam int CHAN_AW   = CH_AW + SUB_AW;

  logic [WORD_W-1:0] data_q, sel_q, load_val;
  logic              start, op_done, op_load;

  // decoded select fields
  bank_e      bank;
  logic       is_rd;
  logic [6:0] slot_idx;
  logic [7:0] chan;
  logic [2:0] sub;
  logic       slot_ok, chan_ok;

  assign bank     = sel_bank(sel_q);
  assign is_rd    = sel_is_read(sel_q);
  assign slot_idx = sel_slot(sel_q);
  assign chan     = sel_chan(sel_q);
  assign sub      = sel_sub(sel_q);
  assign slot_ok  = int'(slot_idx) < NUM_SLOTS;
  assign chan_ok  = (int'(chan) < NUM_CHANNELS) && (int'(sub) < NUM_SUBWORDS);

  cfgwin_host_regs u_regs (
    .clk, .rst_n, .host_valid, .host_write, .host_addr, .host_wdata,
    .host_rdata, .busy, .op_load, .load_val, .start, .data_q, .sel_q
  );

  cfgwin_xfer_ctl #(.XFER_CYCLES(XFER_CYCLES)) u_ctl (
    .clk, .rst_n, .start, .busy, .op_done
  );

  // per-slot banks: index 0 receive, index 1 transmit
  logic [WORD_W-1:0] slot_rd [2];
  logic [1:0]        slot_we;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_slot
      localparam bank_e CODE = (b == 0) ? BANK_RX : BANK_TX;
      assign slot_we[b] = op_done && !is_rd && (bank == CODE) && slot_ok;
      cfgwin_bank_ram #(.DEPTH(NUM_SLOTS), .DW(WORD_W)) u_ram (
        .clk, .rst_n, .we(slot_we[b]), .addr(slot_idx[SLOT_AW-1:0]),
        .wdata(data_q), .rdata(slot_rd[b])
      );
    end
  endgenerate

  logic [WORD_W-1:0] chan_rd;
  logic              chan_we;
  logic [CHAN_AW-1:0] chan_addr;

  assign chan_addr = {chan[CH_AW-1:0], sub[SUB_AW-1:0]};
  assign chan_we   = op_done && !is_rd && (bank == BANK_CHAN) && chan_ok;

  cfgwin_bank_ram #(.DEPTH(CHAN_DEPTH), .DW(WORD_W)) u_chan_ram (
    .clk, .rst_n, .we(chan_we), .addr(chan_addr), .wdata(data_q), .rdata(chan_rd)
  );

  always_comb begin
    unique case (bank)
      BANK_RX:   load_val = slot_ok ? slot_rd[0] : '0;
      BANK_TX:   load_val = slot_ok ? slot_rd[1] : '0;
      BANK_CHAN: load_val = chan_ok ? chan_rd : '0;
      default:   load_val = data_q;
    endcase
  end

  assign op_load = op_done && is_rd && (bank != BANK_NONE);

  // R4: a read transfer leaves the selected entry in the data register
  assert_read_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && is_rd && bank != BANK_NONE) |=> (data_q == $past(load_val)));

  // R7: a transfer with bank code 00 leaves the data register alone
  assert_none_bank_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && bank == BANK_NONE) |=> $stable(data_q));

  // R11: one transfer never writes two banks
  assert_one_bank_written_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $onehot0({slot_we, chan_we}));
endmodule

// File: tb/cfgwin_port_tb.sv
module cfgwin_port_tb_top;
  localparam int XFER = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          chk;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  cfgwin_port #(.XFER_CYCLES(XFER)) dut_i (
    .clk, .rst_n, .host_valid, .host_write, .host_addr, .host_wdata,
    .host_rdata, .busy
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one scoreboard item per completed transfer
  initial begin
    logic prev_busy;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (prev_busy && !busy) begin
        if (sb_q.size() == 0) begin
          check(16'h1, 16'h0, "SB unexpected transfer");
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.chk) check(host_rdata, it.exp, it.tag);
        end
      end
      prev_busy = busy;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0; host_addr = 2'd0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
    #1 host_addr = 2'd0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [15:0] sel, input bit chk, input logic [15:0] exp,
                      input string tag);
    int n;
    item_t it;
    it.chk = chk; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_wr(2'd1, sel);
    wait_idle(n);
    check(16'(n), 16'(XFER), "R3 busy length");
  endtask

  task automatic wr_entry(input logic [15:0] sel, input logic [15:0] d, input string tag);
    bus_wr(2'd0, d);
    xfer(sel & 16'hBFFF, 1'b0, 16'h0, tag);
  endtask

  task automatic rd_entry(input logic [15:0] sel, input logic [15:0] exp, input string tag);
    xfer(sel | 16'h4000, 1'b1, exp, tag);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_rd(2'd0, v); check(v, 16'h0, "R1 data reg");
    bus_rd(2'd1, v); check(v, 16'h0, "R1 select reg");
    bus_rd(2'd2, v); check(v, 16'h0, "R1 status");
    rd_entry(16'h0105, 16'h0, "R1 rx slot 5");
    rd_entry(16'h020A, 16'h0, "R1 tx slot 10");
    rd_entry(16'h1303, 16'h0, "R1 chan 3 sub 2");

    // R2: map
    bus_rd(2'd3, v); check(v, 16'h0, "R2 addr 3");
    bus_wr(2'd0, 16'h5A5A);
    bus_rd(2'd0, v); check(v, 16'h5A5A, "R2 data readback");

    // R4, R5: write then read receive slot 5
    wr_entry(16'h0105, 16'h1234, "R4 write rx 5");
    rd_entry(16'h0105, 16'h1234, "R4 read rx 5");
    bus_rd(2'd1, v); check(v, 16'h4105, "R2 select readback");

    // R11: transmit bank independent
    rd_entry(16'h0205, 16'h0, "R11 tx 5 untouched");
    wr_entry(16'h0205, 16'h0A0A, "R11 write tx 5");
    rd_entry(16'h0105, 16'h1234, "R11 rx 5 kept");
    rd_entry(16'h0205, 16'h0A0A, "R11 tx 5 value");

    // R5: bit 7 ignored for slots; top slot
    rd_entry(16'h0185, 16'h1234, "R5 slot bit7 ignored");
    wr_entry(16'h01FF, 16'h7E7E, "R5 write rx 127");
    rd_entry(16'h017F, 16'h7E7E, "R5 read rx 127");

    // R6: channel bank sub-words
    wr_entry(16'h1303, 16'hBEEF, "R6 write ch3 sub2");
    rd_entry(16'h0303, 16'h0, "R6 ch3 sub0 separate");
    rd_entry(16'h1303, 16'hBEEF, "R6 ch3 sub2");
    wr_entry(16'h3B1F, 16'h5555, "R6 write ch31 sub7");
    rd_entry(16'h3B1F, 16'h5555, "R6 ch31 sub7");

    // R9: out-of-range channel 40 (would alias to 8)
    wr_entry(16'h0328, 16'h7777, "R9 write ch40");
    rd_entry(16'h0328, 16'h0, "R9 ch40 reads 0");
    rd_entry(16'h0308, 16'h0, "R9 ch8 not aliased");

    // R7: bank code 00
    wr_entry(16'h0005, 16'h9999, "R7 write none");
    rd_entry(16'h0105, 16'h1234, "R7 rx 5 unchanged");
    bus_wr(2'd0, 16'hABCD);
    xfer(16'h4005, 1'b1, 16'hABCD, "R7 read none keeps data");

    // R10: read-modify-write of enable bit 15
    rd_entry(16'h0105, 16'h1234, "R10 read before");
    bus_rd(2'd0, v);
    wr_entry(16'h0105, v | 16'h8000, "R10 write back");
    rd_entry(16'h0105, 16'h9234, "R10 enable set, rest kept");

    // R8: writes while busy are ignored
    begin
      int n;
      item_t it;
      it.chk = 1'b1; it.exp = 16'h9234; it.tag = "R8 data write while busy";
      sb_q.push_back(it);
      bus_wr(2'd1, 16'h4105);
      host_addr = 2'd2;
      #1 check(host_rdata, 16'h0001, "R2 status busy bit");
      host_valid = 1'b1; host_write = 1'b1; host_addr = 2'd0; host_wdata = 16'hDEAD;
      @(negedge clk);
      host_addr = 2'd1; host_wdata = 16'h0106;
      @(negedge clk);
      host_valid = 1'b0; host_write = 1'b0; host_addr = 2'd0;
      wait_idle(n);
      check(16'(n), 16'h0, "R8 no second transfer");
      repeat (3) @(negedge clk);
      check(16'(busy), 16'h0, "R8 busy stays low");
      bus_rd(2'd1, v); check(v, 16'h4105, "R8 select not replaced");
      rd_entry(16'h0106, 16'h0, "R8 rx 6 untouched");
    end

    repeat (4) @(negedge clk);
    check(16'(sb_q.size()), 16'h0, "SB drained");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule